// File: doc/BRIEF.md
# Serially Programmed Tapped Delay Element

This block is a clock-synchronous model of a programmable delay element. A one-bit signal enters a chain of unit stages, each one sampling-clock cycle long, and a tap decoder picks how many stages the signal passes through before it reaches the output. The 8-bit tap setting, with 256 values, is loaded over a three-wire serial link made of an enable, a serial clock and a data line. While the enable is high, every rising serial-clock edge pushes one data bit into a shift register, most significant bit first. When the enable falls, the register contents move into a holding latch that drives the tap decoder.

The bit about to leave the shift register is presented on a serial output. Several units can therefore share one enable and serial clock, each unit's data input driven from the previous unit's serial output. The same output allows the setting to be read back: if it is looped to the data input while eight bits are clocked, the register rotates back to its original contents and the setting survives. Clocking without that loop overwrites the setting. All three serial wires are sampled on the sampling clock, so they must be synchronous to it and each serial-clock level must last at least one sampling-clock cycle.

Top module: `serial_tap_delay`

## Requirements
- R1: After reset the shift register and the latch both hold 0, so the serial output is 0 and the delayed output follows the signal input with no added delay.
- R2: While the enable is high, each rising serial-clock edge (seen as a 0-to-1 change between two sampling-clock edges) shifts the data input into bit 0 of the shift register and moves every bit one place toward the most significant bit; the first bit sent ends in bit 7.
- R3: The latch takes the shift register contents on the sampling-clock edge at which the enable is first seen low after being high, and at no other time; bits shifted in while the enable stays high do not alter the delay.
- R4: The serial output is bit 7 of the shift register, so during a transfer it presents, most significant bit first, the value the register held before the transfer, and it can drive the data input of a following unit.
- R5: Clocking eight bits with the serial output fed back to the data input leaves the setting unchanged and returns it on the serial output; clocking eight zero bits without that loop replaces the setting with 0.
- R6: Serial-clock edges while the enable is low are ignored: neither the shift register nor the latch changes.
- R7: With a latched value N, the delayed output equals the signal input as sampled N sampling-clock edges earlier; N = 0 gives the undelayed input.
- R8: The largest setting, 255, delays by 255 cycles, which may span several periods of a periodic input, so any phase of the input can be reached.
- R9: The serial output changes only at a serial-clock rising edge while the enable is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; one unit delay stage per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| serEn | input | 1 | Serial transfer enable; high opens the shift register, the falling edge loads the latch |
| serClk | input | 1 | Serial clock; rising edges shift while enabled |
| serData | input | 1 | Serial data input, most significant bit first |
| serOut | output | 1 | Serial output, shift register bit 7, for cascading or readback |
| sigIn | input | 1 | Signal to be delayed |
| sigOut | output | 1 | Signal after the selected number of unit stages |

## Verification
On every cycle the assertions check that the shift and load strobes never coincide, that the latch changes only on a load strobe and then takes the shift register value, that each shift moves the next bit onto the serial output, that the serial output holds while the enable is low, and that a setting of one gives exactly one cycle of delay. Only the bench scenarios show the end-to-end effect of the serial protocol: the most-significant-first bit order, the loop-back readback that keeps the setting and the unlooped one that destroys it, and delays of 0, small values and 255 measured against a bench-side history of random and periodic inputs.

// File: rtl/tap_delay_pkg.sv
package tap_delay_pkg;

  // Strobes from the serial control to the serial datapath.
  typedef struct packed {
    logic shiftStb;  // push one data bit into the shift register
    logic loadStb;   // copy the shift register into the latch
  } serStrobe_t;

endpackage

// File: rtl/serial_ctrl.sv
module serial_ctrl
  import tap_delay_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       serEn,
  input  logic       serClk,
  output serStrobe_t stb
);

  logic enPrev;
  logic serClkPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enPrev     <= 1'b0;
      serClkPrev <= 1'b0;
    end else begin
      enPrev     <= serEn;
      serClkPrev <= serClk;
    end
  end

  // A serial-clock rise counts only while the enable is high.
  always_comb begin
    stb.shiftStb = serEn && serClk && !serClkPrev;
    stb.loadStb  = enPrev && !serEn;
  end

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.shiftStb, stb.loadStb})); // R6

endmodule

// File: rtl/serial_regs.sv
module serial_regs
  import tap_delay_pkg::*;
#(
  parameter int SET_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  serStrobe_t       stb,
  input  logic             serData,
  output logic             serOut,
  output logic [SET_W-1:0] setting
);

  logic [SET_W-1:0] shiftQ;
  logic [SET_W-1:0] latchQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
    end else if (stb.shiftStb) begin
      shiftQ <= {shiftQ[SET_W-2:0], serData};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ <= '0;
    end else if (stb.loadStb) begin
      latchQ <= shiftQ;
    end
  end

  assign serOut  = shiftQ[SET_W-1];
  assign setting = latchQ;

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadStb |=> $stable(latchQ)); // R3

  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadStb |=> (latchQ == $past(shiftQ))); // R3

  AST_SHIFT_MSB: assert property (@(posedge clk) disable iff (!rstN)
    stb.shiftStb |=> (serOut == $past(shiftQ[SET_W-2]))); // R2

endmodule

// File: rtl/tap_chain.sv
module tap_chain #(
  parameter int SET_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sigIn,
  input  logic [SET_W-1:0] tapSel,
  output logic             sigOut
);

  localparam int STAGES = (1 << SET_W) - 1;

  logic [STAGES-1:0] stageQ;
  logic [STAGES:0]   taps;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageQ[0] <= 1'b0;
    end else begin
      stageQ[0] <= sigIn;
    end
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stageQ[k] <= 1'b0;
      end else begin
        stageQ[k] <= stageQ[k-1];
      end
    end
  end

  // Tap 0 is the raw input, tap N is the output of stage N-1.
  assign taps   = {stageQ, sigIn};
  assign sigOut = taps[tapSel];

endmodule

// File: rtl/serial_tap_delay.sv
module serial_tap_delay
  import tap_delay_pkg::*;
#(
  parameter int SET_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic serEn,
  input  logic serClk,
  input  logic serData,
  output logic serOut,
  input  logic sigIn,
  output logic sigOut
);

  serStrobe_t       stb;
  logic [SET_W-1:0] curSetting;

  serial_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .serEn  (serEn),
    .serClk (serClk),
    .stb    (stb)
  );

  serial_regs #(.SET_W(SET_W)) i_regs (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .serData (serData),
    .serOut  (serOut),
    .setting (curSetting)
  );

  tap_chain #(.SET_W(SET_W)) i_chain (
    .clk    (clk),
    .rstN   (rstN),
    .sigIn  (sigIn),
    .tapSel (curSetting),
    .sigOut (sigOut)
  );

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !serEn |=> $stable(serOut)); // R9

  AST_UNIT_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    ((curSetting == SET_W'(1)) && !stb.loadStb) |=> (sigOut == $past(sigIn))); // R7

endmodule

// File: tb/test_serial_tap_delay.sv
`timescale 1ns/1ps
module test_serial_tap_delay;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serEn = 1'b0;
  logic serClk = 1'b0;
  logic serData = 1'b0;
  logic serOut;
  logic sigIn = 1'b0;
  logic sigOut;

  int checkCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  logic        squareMode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int          phase = 0;
  logic        hist [1:255];

  serial_tap_delay i_serial_tap_delay (
    .clk(clk), .rstN(rstN), .serEn(serEn), .serClk(serClk),
    .serData(serData), .serOut(serOut), .sigIn(sigIn), .sigOut(sigOut)
  );

  always #4 clk = ~clk;

  // Input pattern, changed away from the active edge.
  always @(negedge clk) begin
    lfsr  <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    phase <= (phase == 19) ? 0 : phase + 1;
    sigIn <= squareMode ? (phase < 10) : lfsr[0];
  end

  // Bench history: hist[k] is sigIn as sampled k edges ago.
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 1; i <= 255; i++) hist[i] <= 1'b0;
    end else begin
      for (int i = 255; i >= 2; i--) hist[i] <= hist[i-1];
      hist[1] <= sigIn;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkDelay(input int n, input string tag);
    int bad = 0;
    int act = 0;
    int exp = 0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk); #1;
      if (sigOut !== ((n == 0) ? sigIn : hist[n])) begin
        if (bad == 0) begin
          act = sigOut;
          exp = (n == 0) ? sigIn : hist[n];
        end
        bad++;
      end
    end
    check(bad == 0, tag, act, exp);
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk); serData = b; serClk = 1'b1;
    @(negedge clk); serClk = 1'b0;
  endtask

  task automatic openLink;
    @(negedge clk); serEn = 1'b1;
  endtask

  task automatic closeLink;
    @(negedge clk); serEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic shiftByte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
  endtask

  // Eight clocks with the serial output looped or forced to zero.
  task automatic readBack(input bit loop, output logic [7:0] got);
    got = '0;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); #1;
      got[i] = serOut;
      serData = loop ? serOut : 1'b0;
      serClk = 1'b1;
      @(negedge clk); serClk = 1'b0;
    end
  endtask

  task automatic testReset;
    #1;
    check(serOut === 1'b0, "R1 serial output after reset", serOut, 0);
    checkDelay(0, "R1 zero delay after reset");
  endtask

  task automatic testWriteAndLatch;
    openLink();
    shiftByte(8'h05);
    checkDelay(0, "R3 delay unchanged before enable falls");
    closeLink();
    checkDelay(5, "R7 delay of five after latch");
    openLink();
    shiftByte(8'h01);
    closeLink();
    checkDelay(1, "R7 delay of one");
  endtask

  task automatic testOrderAndReadback;
    logic [7:0] got;
    openLink();
    shiftByte(8'hB2);
    closeLink();
    checkDelay(178, "R2 MSB-first value 0xB2 gives delay 178");
    openLink();
    readBack(1'b1, got);
    check(got == 8'hB2, "R4 serial output returns stored value", got, 8'hB2);
    closeLink();
    checkDelay(178, "R5 looped readback keeps setting");
    openLink();
    readBack(1'b0, got);
    check(got == 8'hB2, "R4 unlooped read still shows value", got, 8'hB2);
    closeLink();
    checkDelay(0, "R5 unlooped read clears setting");
  endtask

  task automatic testIgnoredClocks;
    logic [7:0] got;
    logic hold;
    openLink();
    shiftByte(8'h3C);
    closeLink();
    @(negedge clk); #1;
    hold = serOut;
    begin
      int moved = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk); serData = ~serData; serClk = 1'b1;
        @(negedge clk); serClk = 1'b0; #1;
        if (serOut !== hold) moved++;
      end
      check(moved == 0, "R9 serial output holds while disabled", moved, 0);
    end
    checkDelay(60, "R6 disabled clocks leave latch alone");
    openLink();
    readBack(1'b1, got);
    closeLink();
    check(got == 8'h3C, "R6 disabled clocks leave register alone", got, 8'h3C);
  endtask

  task automatic testMaxDelay;
    openLink();
    shiftByte(8'hFF);
    closeLink();
    checkDelay(255, "R8 full delay with random input");
    squareMode = 1'b1;
    checkDelay(255, "R8 delay spanning many square-wave periods");
    squareMode = 1'b0;
    openLink();
    shiftByte(8'h00);
    closeLink();
    checkDelay(0, "R7 back to zero delay");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testWriteAndLatch();
    testOrderAndReadback();
    testIgnoredClocks();
    testMaxDelay();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

endmodule